// File: doc/BRIEF.md
# Bit interleave and byte parity unit

This unit carries out three bit-manipulation operations for the execute stage of a 32-bit processor. An operation select input picks one of them. Merge weaves the low halves of two operands into one word, one bit from each in turn. Split does the reverse: it pulls the even and the odd bit positions of one word apart into two half-width results, each returned zero-extended to a full word. Parity reduces each byte of a word to its XOR and places that bit at the byte's lowest position.

The two results appear on a low and a high output word. A high-valid flag tells the register-file write logic whether the high word must be written too. Only split sets it. Split puts its low word in the even register of a destination pair and its high word in the odd register that follows. Merge and parity write a single destination register.

The operation logic is combinational. The result is captured in one output register stage, so a result is visible on the outputs after the first rising clock edge that follows the inputs. The word width and the parity group size are parameters. The defaults are 32 and 8.

Top module: `bip_unit`

## Requirements
- R1: While reset is asserted (rst_n low), res_lo and res_hi are zero and res_hi_vld is 0.
- R2: The outputs change only on a rising clock edge. Inputs presented before an edge show on the outputs from that edge on, and the outputs stay stable between edges.
- R3: With op_sel = 2'b00 (merge), res_lo bit 2i+1 equals src_a bit i and res_lo bit 2i equals src_b bit i, for i = 0 to 15.
- R4: In merge, bits 16 to 31 of src_a and of src_b have no effect on any output.
- R5: With op_sel = 2'b01 (split), res_lo bit i equals src_a bit 2i and res_hi bit i equals src_a bit 2i+1, for i = 0 to 15. Bits 16 to 31 of both results are zero, and src_b has no effect.
- R6: With op_sel = 2'b10 (parity), res_lo bit 8k is the XOR of bits 8k to 8k+7 of src_a, for k = 0 to 3. Every other bit of res_lo is zero, and src_b has no effect.
- R7: res_hi_vld is 1 only for split. For merge and parity it is 0 and res_hi is zero.
- R8: With op_sel = 2'b11 (unused code), res_lo and res_hi are zero and res_hi_vld is 0.
- R9: Splitting a word x and then merging with the split high word as src_a and the split low word as src_b returns x on res_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 2 | Operation: 00 merge, 01 split, 10 parity, 11 unused |
| src_a | input | 32 | First operand; the only source for split and parity |
| src_b | input | 32 | Second operand, used by merge only |
| res_lo | output | 32 | Low result word (the even register for split) |
| res_hi | output | 32 | High result word (the odd register for split) |
| res_hi_vld | output | 1 | High result word is to be written |

## Verification
The bench walks a single one across all 32 positions of each operand for every operation. This catches a design that swaps the two operands in merge, swaps the even and odd streams in split, or shifts a parity bit to the wrong place in its byte. The walks through the upper operand halves show whether merge leaks ignored bits or split and parity fill the upper result bits. A wrong unused-code case or a wrong high-valid decode appears as a stray write flag or as nonzero data. A split-then-merge round trip on random words catches an off-by-one in either permutation that the two directions would otherwise hide from each other. A latency probe checks that nothing passes through the register before its clock edge.

// File: rtl/bip_pkg.sv
package bip_pkg;

    // Operation select codes
    typedef enum logic [1:0] {
        OP_MERGE  = 2'b00,
        OP_SPLIT  = 2'b01,
        OP_PARITY = 2'b10,
        OP_NONE   = 2'b11
    } bip_op_e;

    // Bit positions that may carry a parity result: the lowest bit of each group
    function automatic logic [63:0] parity_pos_mask(input int unsigned width,
                                                    input int unsigned grp);
        logic [63:0] m;
        m = '0;
        for (int unsigned n = 0; n < width; n++) begin
            if ((n % grp) == 0) begin
                m[n] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/bip_merge.sv
module bip_merge #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [HALF_W-1:0] odd_src,
    input  logic [HALF_W-1:0] even_src,
    output logic [DATA_W-1:0] merged
);

    // odd_src supplies the odd result positions, even_src the even ones
    for (genvar i = 0; i < HALF_W; i++) begin : g_weave
        assign merged[2*i+1] = odd_src[i];
        assign merged[2*i]   = even_src[i];
    end

endmodule

// File: rtl/bip_split.sv
module bip_split #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] even_out,
    output logic [DATA_W-1:0] odd_out
);

    for (genvar i = 0; i < HALF_W; i++) begin : g_unweave
        assign even_out[i] = src[2*i];
        assign odd_out[i]  = src[2*i+1];
    end

    // Upper halves of both results are zero-extended
    assign even_out[DATA_W-1:HALF_W] = '0;
    assign odd_out[DATA_W-1:HALF_W]  = '0;

endmodule

// File: rtl/bip_parity.sv
module bip_parity #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GROUP_W = 8,
    localparam int unsigned N_GRP  = DATA_W / GROUP_W
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] par
);

    for (genvar k = 0; k < N_GRP; k++) begin : g_grp
        // Parity of group k lands on its lowest bit
        assign par[k*GROUP_W] = ^src[k*GROUP_W +: GROUP_W];
        if (GROUP_W > 1) begin : g_fill
            assign par[k*GROUP_W+1 +: GROUP_W-1] = '0;
        end
    end

endmodule

// File: rtl/bip_unit.sv
module bip_unit #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PAR_GRP = 8,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi,
    output logic              res_hi_vld
);
    import bip_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic              hi_vld;
    } res_t;

    res_t    res_d, res_q;
    bip_op_e op_e;

    logic [DATA_W-1:0] merge_w;
    logic [DATA_W-1:0] split_even_w;
    logic [DATA_W-1:0] split_odd_w;
    logic [DATA_W-1:0] parity_w;

    assign op_e = bip_op_e'(op_sel);

    bip_merge #(.DATA_W(DATA_W)) u_merge (
        .odd_src  (src_a[HALF_W-1:0]),
        .even_src (src_b[HALF_W-1:0]),
        .merged   (merge_w)
    );

    bip_split #(.DATA_W(DATA_W)) u_split (
        .src      (src_a),
        .even_out (split_even_w),
        .odd_out  (split_odd_w)
    );

    bip_parity #(.DATA_W(DATA_W), .GROUP_W(PAR_GRP)) u_parity (
        .src (src_a),
        .par (parity_w)
    );

    // Next-value selection
    always_comb begin
        res_d = '0;
        unique case (op_e)
            OP_MERGE: begin
                res_d.lo = merge_w;
            end
            OP_SPLIT: begin
                res_d.lo     = split_even_w;
                res_d.hi     = split_odd_w;
                res_d.hi_vld = 1'b1;
            end
            OP_PARITY: begin
                res_d.lo = parity_w;
            end
            default: begin
                res_d = '0;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_lo     = res_q.lo;
    assign res_hi     = res_q.hi;
    assign res_hi_vld = res_q.hi_vld;

endmodule

// File: rtl/bip_unit_chk.sv
module bip_unit_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PAR_GRP = 8,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] res_lo,
    input logic [DATA_W-1:0] res_hi,
    input logic              res_hi_vld
);
    localparam logic [63:0] PMASK64 = bip_pkg::parity_pos_mask(DATA_W, PAR_GRP);
    localparam logic [DATA_W-1:0] PMASK = PMASK64[DATA_W-1:0];

    // Number of clock edges since reset, saturating at 2
    logic [1:0] armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 2'd0;
        end else if (armed != 2'd2) begin
            armed <= armed + 2'd1;
        end
    end

    // R7: the high-valid flag follows the previous cycle's operation
    p_hi_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed != 2'd0) |-> (res_hi_vld == ($past(op_sel) == 2'b01)));

    // R5: split results carry nothing in their upper halves
    p_split_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi_vld |-> (res_lo[DATA_W-1:HALF_W] == '0 && res_hi[DATA_W-1:HALF_W] == '0));

    // R6: parity only uses the lowest bit of each group
    p_parity_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((armed != 2'd0) && $past(op_sel) == 2'b10) |-> ((res_lo & ~PMASK) == '0 && res_hi == '0));

    // R8: the unused code produces all zeros
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((armed != 2'd0) && $past(op_sel) == 2'b11) |-> (res_lo == '0 && res_hi == '0 && !res_hi_vld));

    // R4: two merges with equal low halves give the same result
    p_merge_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((armed == 2'd2) && $past(op_sel) == 2'b00 && $past(op_sel, 2) == 2'b00 &&
         $past(src_a[HALF_W-1:0]) == $past(src_a[HALF_W-1:0], 2) &&
         $past(src_b[HALF_W-1:0]) == $past(src_b[HALF_W-1:0], 2)) |-> $stable(res_lo));

endmodule

bind bip_unit bip_unit_chk #(.DATA_W(DATA_W), .PAR_GRP(PAR_GRP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .src_a      (src_a),
    .src_b      (src_b),
    .res_lo     (res_lo),
    .res_hi     (res_hi),
    .res_hi_vld (res_hi_vld)
);

// File: tb/sim_bip_unit.sv
module sim_bip_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_sel;
    logic [31:0] src_a, src_b;
    logic [31:0] res_lo, res_hi;
    logic        res_hi_vld;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bip_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .res_lo(res_lo), .res_hi(res_hi), .res_hi_vld(res_hi_vld)
    );

    // Reference model written from the requirements
    function automatic logic [31:0] ref_merge(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            r[2*i+1] = a[i];
            r[2*i]   = b[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_split(input logic [31:0] x, input bit odd);
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++) r[i] = odd ? x[2*i+1] : x[2*i];
        return r;
    endfunction

    function automatic logic [31:0] ref_parity(input logic [31:0] x);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            logic p = 1'b0;
            for (int j = 0; j < 8; j++) p = p ^ x[8*k+j];
            r[8*k] = p;
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present inputs at a falling edge; return at the next falling edge
    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b;
        @(negedge clk);
    endtask

    task automatic run_and_check(input string req, input logic [1:0] op,
                                 input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e_lo, e_hi;
        logic        e_v;
        e_lo = '0; e_hi = '0; e_v = 1'b0;
        case (op)
            2'b00: e_lo = ref_merge(a, b);
            2'b01: begin e_lo = ref_split(a, 1'b0); e_hi = ref_split(a, 1'b1); e_v = 1'b1; end
            2'b10: e_lo = ref_parity(a);
            default: ;
        endcase
        apply(op, a, b);
        chk(req, "res_lo", res_lo, e_lo);
        chk(req, "res_hi", res_hi, e_hi);
        chk(req, "res_hi_vld", {31'd0, res_hi_vld}, {31'd0, e_v});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; op_sel = 2'b01; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "res_lo in reset", res_lo, 32'h0);
        chk("R1", "res_hi in reset", res_hi, 32'h0);
        chk("R1", "res_hi_vld in reset", {31'd0, res_hi_vld}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_merge_walk;
        for (int i = 0; i < 32; i++) begin
            run_and_check("R3", 2'b00, 32'h1 << i, 32'h0);
            run_and_check("R3", 2'b00, 32'h0, 32'h1 << i);
        end
        run_and_check("R3", 2'b00, 32'h0000_FFFF, 32'h0000_0000);
        run_and_check("R3", 2'b00, 32'h0000_0000, 32'h0000_FFFF);
    endtask

    task automatic t_merge_ignore;
        logic [31:0] base;
        apply(2'b00, 32'h0000_A5C3, 32'h0000_3C5A);
        base = res_lo;
        apply(2'b00, 32'hFFFF_A5C3, 32'h1234_3C5A);
        chk("R4", "merge with upper bits set", res_lo, base);
        chk("R4", "merge res_hi", res_hi, 32'h0);
        run_and_check("R4", 2'b00, 32'hFFFF_0000, 32'hFFFF_0000);
    endtask

    task automatic t_split_walk;
        for (int i = 0; i < 32; i++) run_and_check("R5", 2'b01, 32'h1 << i, 32'h0);
        run_and_check("R5", 2'b01, 32'hFFFF_FFFF, 32'h0);
        run_and_check("R5", 2'b01, 32'h5555_5555, 32'h0);
        run_and_check("R5", 2'b01, 32'hAAAA_AAAA, 32'hFFFF_FFFF);
    endtask

    task automatic t_parity_walk;
        for (int i = 0; i < 32; i++) run_and_check("R6", 2'b10, 32'h1 << i, 32'hFFFF_FFFF);
        run_and_check("R6", 2'b10, 32'hFFFF_FFFF, 32'h0);
        run_and_check("R6", 2'b10, 32'h0103_0701, 32'h0);
        run_and_check("R6", 2'b10, 32'h0, 32'h0);
    endtask

    task automatic t_hi_valid;
        run_and_check("R7", 2'b01, 32'hDEAD_BEEF, 32'h0);
        run_and_check("R7", 2'b00, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        run_and_check("R7", 2'b10, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    endtask

    task automatic t_unused;
        run_and_check("R8", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_and_check("R8", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_and_check("R8", 2'b11, 32'h1357_9BDF, 32'h2468_ACE0);
    endtask

    task automatic t_latency;
        apply(2'b00, 32'h0000_FFFF, 32'h0);
        @(negedge clk);
        op_sel = 2'b01; src_a = 32'hFFFF_FFFF; src_b = 32'h0;
        #1;
        chk("R2", "res_lo before edge", res_lo, 32'hAAAA_AAAA);
        chk("R2", "res_hi_vld before edge", {31'd0, res_hi_vld}, 32'h0);
        @(posedge clk);
        #1;
        chk("R2", "res_lo after edge", res_lo, 32'h0000_FFFF);
        chk("R2", "res_hi after edge", res_hi, 32'h0000_FFFF);
        chk("R2", "res_hi_vld after edge", {31'd0, res_hi_vld}, 32'h1);
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++) begin
            run_and_check("R3", 2'b00, $urandom, $urandom);
            run_and_check("R5", 2'b01, $urandom, $urandom);
            run_and_check("R6", 2'b10, $urandom, $urandom);
        end
    endtask

    task automatic t_roundtrip;
        logic [31:0] x, lo, hi;
        for (int n = 0; n < 100; n++) begin
            x = (n == 0) ? 32'h8000_0001 : $urandom;
            apply(2'b01, x, 32'h0);
            lo = res_lo; hi = res_hi;
            apply(2'b00, hi, lo);
            chk("R9", "split then merge", res_lo, x);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_merge_walk();
        t_merge_ignore();
        t_split_walk();
        t_parity_walk();
        t_hi_valid();
        t_unused();
        t_random();
        t_roundtrip();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule